// File: doc/BRIEF.md
# Core-Memory Emulator Sense Pulse Sequencer

This block takes the place of a magnetic-core storage unit behind an old-style storage cycle. The host raises a read control during the readout half of its cycle and a write control during the write-back half. A small synchronous RAM holds the words. A rising edge on the read control starts a timed sequence. The addressed 16-bit word is fetched, and one odd parity bit is formed for each 8-bit half. After a fixed delay, every sense output whose bit is 1 gives one short active-low pulse.

Both controls come from another clock domain. Each passes through a two-flop synchronizer, and edges are found on the synchronized copies. While a sequence is running, further read edges and all write edges are dropped. A dip on the read line therefore cannot start a second pulse train, and it cannot change memory behind the read.

Top module: `coreSenseEmu`

## Requirements
- R1: A read starts only on a rising edge of `rdCtl`. Holding `rdCtl` high produces exactly one pulse train.
- R2: Number the clock edges after `rdCtl` rises, starting with the first edge as 1. `senseN` stays all ones through edge DELAY_CYC+3 and first goes low just after edge DELAY_CYC+4.
- R3: The pulse is active low and lasts exactly PULSE_CYC clock cycles. After it, all outputs return high.
- R4: During the pulse, only outputs whose bit is 1 go low. Outputs for 0 bits stay high for the whole sequence.
- R5: Bit mapping: `senseN[15:0]` carry data bits 15..0. `senseN[16]` carries the parity of data[7:0]. `senseN[17]` carries the parity of data[15:8].
- R6: Each parity bit makes the count of ones in its half plus itself odd. An all-zero half and an all-ones half both give parity 1.
- R7: A rising edge of `rdCtl` while a sequence is waiting or pulsing is ignored. No second train follows, and the timing of the first train is unchanged.
- R8: A rising edge of `wrCtl` while idle writes `wrData` into the word at `addr`. Both are sampled on the third clock edge after the edge on `wrCtl`.
- R9: A rising edge of `wrCtl` during a read sequence is ignored, and memory keeps its old word.
- R10: When rising edges of `rdCtl` and `wrCtl` reach the idle block in the same cycle, the read runs and the write is dropped.
- R11: During and right after reset, all `senseN` outputs are high and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdCtl | input | 1 | Read control from the host, asynchronous |
| wrCtl | input | 1 | Write control from the host, asynchronous |
| addr | input | ADDR_W | Word address, held stable by the host through the cycle |
| wrData | input | 16 | Word to store on a write |
| senseN | output | 18 | Active-low sense pulses: 16 data bits, then the low-half parity, then the high-half parity |

## Verification
The bench builds the block with DELAY_CYC=12, PULSE_CYC=3 and ADDR_W=4. With these values, every quiet cycle, every pulse cycle and the return edge of each train is checked one cycle at a time, and it stays cheap to do so. The short delay window allows a read-line dip and a competing write edge to be placed inside a running sequence, so the lockout can be observed at the outputs. The 16-word memory lets several parity patterns sit at separate addresses and be read back after the ignored writes.

// File: rtl/coreSensePkg.sv
package coreSensePkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_WAIT, SEQ_PULSE} seqState_e;

  typedef struct packed {
    logic readLatch;
    logic memWrite;
    logic pulseOn;
  } seqStrobe_t;
endpackage

// File: rtl/coreSenseSync.sv
module coreSenseSync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/coreSenseCtrl.sv
module coreSenseCtrl
  import coreSensePkg::*;
#(
  parameter int DELAY_CYC   = 80,
  parameter int PULSE_CYC   = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdCtl,
  input  logic       wrCtl,
  output seqStrobe_t strb
);
  localparam int CNT_MAX = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_CYC - 1);
  localparam logic [CNT_W-1:0] PUL_LAST = CNT_W'(PULSE_CYC - 1);

  logic rdSync, wrSync, rdPrev, wrPrev;
  logic rdRise, wrRise;
  seqState_e state, stateNext;
  logic [CNT_W-1:0] cnt;

  coreSenseSync #(.STAGES(SYNC_STAGES), .WIDTH(2)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({wrCtl, rdCtl}),
    .syncOut({wrSync, rdSync})
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev <= 1'b0;
      wrPrev <= 1'b0;
    end else begin
      rdPrev <= rdSync;
      wrPrev <= wrSync;
    end
  end

  assign rdRise = rdSync & ~rdPrev;
  assign wrRise = wrSync & ~wrPrev;

  always_comb begin
    stateNext = state;
    unique case (state)
      SEQ_IDLE:  if (rdRise)          stateNext = SEQ_WAIT;
      SEQ_WAIT:  if (cnt == DLY_LAST) stateNext = SEQ_PULSE;
      SEQ_PULSE: if (cnt == PUL_LAST) stateNext = SEQ_IDLE;
      default:                        stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= SEQ_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      if (stateNext != state) cnt <= '0;
      else if (state != SEQ_IDLE) cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    strb.readLatch = (state == SEQ_IDLE) && rdRise;
    strb.memWrite  = (state == SEQ_IDLE) && wrRise && !rdRise;
    strb.pulseOn   = (state == SEQ_PULSE);
  end

  // R1: a sequence only begins after a detected rising edge of the read line
  a_r1_edge_start: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_WAIT && $past(state) == SEQ_IDLE) |-> ($past(rdSync) && !$past(rdPrev)));

  // R2: the pulse phase is entered only once the full delay has elapsed
  a_r2_full_delay: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_PULSE && $past(state) != SEQ_PULSE) |-> ($past(state) == SEQ_WAIT && $past(cnt) == DLY_LAST));

  // R3: the pulse phase ends only after its full length
  a_r3_pulse_len: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_IDLE && $past(state) == SEQ_PULSE) |-> ($past(cnt) == PUL_LAST));

  // R7, R9: no read restart and no memory write while a sequence runs
  a_r9_busy_lockout: assert property (@(posedge clk) disable iff (!rstN)
    (state != SEQ_IDLE) |-> (!strb.memWrite && !strb.readLatch));
endmodule

// File: rtl/coreSenseDatapath.sv
module coreSenseDatapath
  import coreSensePkg::*;
#(
  parameter int DATA_W = 16,
  parameter int HALF_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  seqStrobe_t                            strb,
  input  logic [ADDR_W-1:0]                     addr,
  input  logic [DATA_W-1:0]                     wrData,
  output logic [DATA_W+DATA_W/HALF_W-1:0]       senseN
);
  localparam int NPAR    = DATA_W / HALF_W;
  localparam int SENSE_W = DATA_W + NPAR;
  localparam int DEPTH   = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdWord;
  logic [NPAR-1:0]   parBits;

  always_ff @(posedge clk) begin
    if (strb.memWrite) mem[addr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rdWord <= '0;
    else if (strb.readLatch) rdWord <= mem[addr];
  end

  for (genvar g = 0; g < NPAR; g++) begin : gPar
    assign parBits[g] = ~^rdWord[g*HALF_W +: HALF_W];

    // R6: every low pulse pattern holds an odd count of ones per half plus parity
    a_r6_odd_half: assert property (@(posedge clk) disable iff (!rstN)
      (senseN != '1) |-> ((^(~{senseN[g*HALF_W +: HALF_W], senseN[DATA_W+g]})) == 1'b1));
  end

  always_ff @(posedge clk) begin
    if (!rstN)             senseN <= '1;
    else if (strb.pulseOn) senseN <= ~{parBits, rdWord};
    else                   senseN <= '1;
  end

  // R4: the pattern stays fixed for the whole pulse
  a_r4_steady_pattern: assert property (@(posedge clk) disable iff (!rstN)
    ($past(senseN) != '1 && senseN != '1) |-> $stable(senseN));

  // R10: a read and a write never act in the same cycle
  a_r10_rw_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.memWrite && strb.readLatch));

  // R11: outputs are released in the cycle after reset
  a_r11_reset_release: assert property (@(posedge clk)
    $past(!rstN) |-> (senseN == {SENSE_W{1'b1}}));
endmodule

// File: rtl/coreSenseEmu.sv
module coreSenseEmu
  import coreSensePkg::*;
#(
  parameter int DELAY_CYC   = 80,
  parameter int PULSE_CYC   = 9,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdCtl,
  input  logic              wrCtl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wrData,
  output logic [17:0]       senseN
);
  seqStrobe_t strb;

  coreSenseCtrl #(
    .DELAY_CYC  (DELAY_CYC),
    .PULSE_CYC  (PULSE_CYC),
    .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk  (clk),
    .rstN (rstN),
    .rdCtl(rdCtl),
    .wrCtl(wrCtl),
    .strb (strb)
  );

  coreSenseDatapath #(
    .DATA_W(16),
    .HALF_W(8),
    .ADDR_W(ADDR_W)
  ) uData (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .addr  (addr),
    .wrData(wrData),
    .senseN(senseN)
  );
endmodule

// File: tb/sim_coreSenseEmu.sv
module sim_coreSenseEmu;
  localparam int DLY = 12;
  localparam int PUL = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rdCtl = 1'b0;
  logic wrCtl = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wrData = '0;
  logic [17:0] senseN;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  coreSenseEmu #(.DELAY_CYC(DLY), .PULSE_CYC(PUL), .ADDR_W(4)) u0 (
    .clk(clk), .rstN(rstN), .rdCtl(rdCtl), .wrCtl(wrCtl),
    .addr(addr), .wrData(wrData), .senseN(senseN)
  );

  localparam logic [19:0] VEC [6] = '{
    {4'd0, 16'h0000}, {4'd1, 16'hFFFF}, {4'd2, 16'h00FF},
    {4'd3, 16'h0100}, {4'd4, 16'h8001}, {4'd8, 16'hA5C3}
  };

  function automatic logic oddPar(input logic [7:0] h);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(h[i]);
    return (ones % 2 == 0);
  endfunction

  function automatic logic [17:0] expLow(input logic [15:0] w);
    return ~{oddPar(w[15:8]), oddPar(w[7:0]), w};
  endfunction

  task automatic check(input string what, input logic [17:0] act, input logic [17:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doWrite(input logic [3:0] a, input logic [15:0] w);
    addr = a; wrData = w; wrCtl = 1'b1;
    cyc(5);
    wrCtl = 1'b0;
    cyc(3);
  endtask

  // mode 0 plain, 1 read-line dip, 2 write during sequence, 3 write rising together
  task automatic doRead(input logic [3:0] a, input logic [15:0] w, input int mode, input string tag);
    logic quiet = 1'b1;
    addr = a; rdCtl = 1'b1;
    if (mode == 3) begin wrData = 16'h5555; wrCtl = 1'b1; end
    for (int i = 1; i <= DLY + 3; i++) begin
      cyc(1);
      if (senseN !== '1) quiet = 1'b0;
      if (mode == 1 && i == 6) rdCtl = 1'b0;
      if (mode == 1 && i == 8) rdCtl = 1'b1;
      if (mode == 2 && i == 4) begin wrData = 16'hBEEF; wrCtl = 1'b1; end
      if (mode >= 2 && i == 9) wrCtl = 1'b0;
    end
    check({tag, " R2 quiet before delay"}, {17'b0, quiet}, 18'd1);
    for (int p = 0; p < PUL; p++) begin
      cyc(1);
      check({tag, " R3 R4 R5 pulse pattern"}, senseN, expLow(w));
    end
    cyc(1);
    check({tag, " R3 released after pulse"}, senseN, '1);
  endtask

  task automatic watchIdle(input int n, input string what);
    logic quiet = 1'b1;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (senseN !== '1) quiet = 1'b0;
    end
    check(what, {17'b0, quiet}, 18'd1);
  endtask

  initial begin
    cyc(1);
    check("R11 outputs high in reset", senseN, '1);
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    check("R11 outputs high after reset", senseN, '1);

    // table walk: R8 writes, then R4 R5 R6 patterns read back
    for (int v = 0; v < 6; v++) doWrite(VEC[v][19:16], VEC[v][15:0]);
    for (int v = 0; v < 6; v++) begin
      doRead(VEC[v][19:16], VEC[v][15:0], 0, "R8 R6 table");
      rdCtl = 1'b0;
      cyc(4);
    end

    // R1: level held high gives one train only
    doRead(4'd4, 16'h8001, 0, "R1 level");
    watchIdle(3 * (DLY + PUL), "R1 no retrigger on held level");
    rdCtl = 1'b0;
    cyc(4);

    // R7: dip on the read line during the delay
    doWrite(4'd9, 16'h1234);
    doRead(4'd9, 16'h1234, 1, "R7 dip");
    watchIdle(DLY + PUL + 8, "R7 no second train after dip");
    rdCtl = 1'b0;
    cyc(4);

    // R9: write edge during a running sequence is dropped
    doWrite(4'd5, 16'h0F0F);
    doRead(4'd5, 16'h0F0F, 2, "R9 busy write");
    rdCtl = 1'b0;
    cyc(4);
    doRead(4'd5, 16'h0F0F, 0, "R9 memory unchanged");
    rdCtl = 1'b0;
    cyc(4);

    // R10: simultaneous edges, read wins
    doWrite(4'd7, 16'h00FF);
    doRead(4'd7, 16'h00FF, 3, "R10 read wins");
    rdCtl = 1'b0;
    cyc(4);
    doRead(4'd7, 16'h00FF, 0, "R10 write dropped");
    rdCtl = 1'b0;
    cyc(4);

    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule